// File: doc/BRIEF.md
# Descriptor Ring Queue Tracker

This block keeps the bookkeeping of a circular descriptor queue shared between software and a memory-to-memory DMA engine. Software sets how many entries the ring holds, then announces newly written descriptors by writing a batch count rather than a pointer. The tracker turns that count into a stream of single-entry fetch requests toward the engine's back end, one ring index per accepted handshake. It then counts each completion pulse the engine returns.

Completed entries are not released on their own. Software reads a status word holding the number of finished but unreleased descriptors and the ring index of the oldest such entry. After servicing them it writes a release count, which lowers the finished count and moves the release index forward. A halt control gates the fetch stream without disturbing any pointer. Descriptor storage, bus mastering and the data operations live elsewhere.

Top module: `desc_ring_tracker`

## Requirements
- R1: After reset the producer, fetch and release indices, the outstanding count, the finished count and the error flag are 0, the halt bit reads 1, the ring size reads 4096 (DEPTH_MAX) and fetchReq is low.
- R2: A write to address 0 sets the ring size only when the value is between 1 and DEPTH_MAX. Any other value leaves the size unchanged. Reading address 0 returns the size.
- R3: Writing N to address 1 adds N to the outstanding count. It also advances the producer index by N modulo the ring size, and that index reads back in bits [31:16] of address 5.
- R4: fetchReq is high exactly when the outstanding count is non-zero and the halt bit is 0. Each cycle with fetchReq and fetchGnt both high lowers the outstanding count by one and moves fetchIdx to the next index, wrapping from size-1 to 0. fetchIdx holds in every other cycle.
- R5: Writing to address 3 loads bit 0 into the halt bit. With the halt bit at 1, fetchReq is low from the next cycle on, and no pointer moves because of it.
- R6: Each cycle with doneIn high adds one to the finished count, which reads back in bits [14:0] of address 4.
- R7: Writing N to address 2, when N does not exceed the finished count, subtracts N from that count. It also advances the release index, read in bits [28:16] of address 4, by N modulo the ring size.
- R8: A release count larger than the finished count (including that cycle's doneIn) sets the finished count to 0 and advances the release index by the entries actually held. It also sets bit 31 of address 4, which stays set until reset.
- R9: A doneIn pulse and a release write in the same cycle are both applied: the new finished count is old + 1 - N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for write and read |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational read data for regAddr |
| fetchReq | output | 1 | A descriptor index is ready for the engine |
| fetchIdx | output | IDX_W (13) | Ring index offered with fetchReq |
| fetchGnt | input | 1 | Engine accepts the offered index |
| doneIn | input | 1 | One descriptor completed (pulse per descriptor) |

## Verification
The finished count has two writers that can hit the same edge: the engine's completion pulse and the software release write. The bench provokes the collision on purpose in directed steps, once with an in-range count and once with a count that exceeds the held entries. The random phase drives doneIn on about a third of cycles while issuing release writes, so the two meet often. Each resulting count, release index and error bit is judged against a bench model that applies old + pulse - count, with the saturating rule, before comparing the status word.

// File: rtl/desc_ring_pkg.sv
package desc_ring_pkg;

  // width of a batch count carried on the strobe bundle
  localparam int STEP_W = 16;

  typedef enum logic [2:0] {
    REG_SIZE  = 3'd0,
    REG_ADD   = 3'd1,
    REG_FREE  = 3'd2,
    REG_HALT  = 3'd3,
    REG_DONE  = 3'd4,
    REG_ALLOC = 3'd5
  } regSel_e;

  typedef struct packed {
    logic              addEn;
    logic [STEP_W-1:0] addCnt;
    logic              freeEn;
    logic [STEP_W-1:0] freeCnt;
    logic              fetchStep;
    logic              doneStep;
  } ringStrobe_t;

endpackage

// File: rtl/ring_ctrl.sv
module ring_ctrl
  import desc_ring_pkg::*;
#(
  parameter int IDX_W     = 13,
  parameter int DONE_W    = 15,
  parameter int DEPTH_MAX = 1 << IDX_W,
  localparam int SIZE_W   = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              fetchGnt,
  input  logic              doneIn,
  input  logic              hasWork,
  input  logic [IDX_W-1:0]  prodIdx,
  input  logic [IDX_W-1:0]  reclaimIdx,
  input  logic [DONE_W-1:0] doneCnt,
  input  logic              freeErr,
  output logic              fetchReq,
  output logic [SIZE_W-1:0] queueSize,
  output ringStrobe_t       strobe
);

  logic haltReg;
  logic sizeOk;

  assign sizeOk = (regWrData != '0) && (regWrData <= 32'(DEPTH_MAX));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      haltReg   <= 1'b1;
      queueSize <= SIZE_W'(DEPTH_MAX);
    end else if (regWrEn) begin
      if (regAddr == REG_HALT) haltReg <= regWrData[0];
      if (regAddr == REG_SIZE && sizeOk) queueSize <= regWrData[SIZE_W-1:0];
    end
  end

  assign fetchReq = hasWork && !haltReg;

  always_comb begin
    strobe           = '0;
    strobe.addEn     = regWrEn && (regAddr == REG_ADD);
    strobe.addCnt    = regWrData[STEP_W-1:0];
    strobe.freeEn    = regWrEn && (regAddr == REG_FREE);
    strobe.freeCnt   = regWrData[STEP_W-1:0];
    strobe.fetchStep = fetchReq && fetchGnt;
    strobe.doneStep  = doneIn;
  end

  always_comb begin
    regRdData = '0;
    case (regSel_e'(regAddr))
      REG_SIZE:  regRdData[SIZE_W-1:0] = queueSize;
      REG_HALT:  regRdData[0] = haltReg;
      REG_DONE: begin
        regRdData[DONE_W-1:0]  = doneCnt;
        regRdData[16 +: IDX_W] = reclaimIdx;
        regRdData[31]          = freeErr;
      end
      REG_ALLOC: regRdData[16 +: IDX_W] = prodIdx;
      default:   regRdData = '0;
    endcase
  end

endmodule

// File: rtl/ring_datapath.sv
module ring_datapath
  import desc_ring_pkg::*;
#(
  parameter int IDX_W  = 13,
  parameter int DONE_W = 15,
  localparam int SIZE_W = IDX_W + 1,
  localparam int SUM_W  = STEP_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ringStrobe_t       strobe,
  input  logic [SIZE_W-1:0] queueSize,
  output logic [IDX_W-1:0]  prodIdx,
  output logic [IDX_W-1:0]  fetchIdx,
  output logic [IDX_W-1:0]  reclaimIdx,
  output logic [DONE_W-1:0] doneCnt,
  output logic              freeErr,
  output logic              hasWork
);

  logic [STEP_W-1:0] pendCnt;
  logic [STEP_W-1:0] pendNext;
  logic [DONE_W-1:0] doneNext;
  logic [STEP_W-1:0] relStep;
  logic              overFree;
  logic [STEP_W:0]   doneSum;

  // advance an index by step (step not above the ring size), modulo size
  function automatic logic [IDX_W-1:0] wrapAdd(input logic [IDX_W-1:0]  base,
                                               input logic [STEP_W-1:0] step,
                                               input logic [SIZE_W-1:0] lim);
    logic [SUM_W-1:0] sum;
    sum = SUM_W'(base) + SUM_W'(step);
    if (sum >= SUM_W'(lim)) sum = sum - SUM_W'(lim);
    return sum[IDX_W-1:0];
  endfunction

  assign hasWork = (pendCnt != '0);

  always_comb begin
    pendNext = pendCnt - STEP_W'(strobe.fetchStep);
    if (strobe.addEn) pendNext = pendNext + strobe.addCnt;
  end

  always_comb begin
    doneSum  = (STEP_W+1)'(doneCnt) + (STEP_W+1)'(strobe.doneStep);
    overFree = strobe.freeEn && ((STEP_W+1)'(strobe.freeCnt) > doneSum);
    if (!strobe.freeEn) begin
      doneNext = doneSum[DONE_W-1:0];
      relStep  = '0;
    end else if (overFree) begin
      doneNext = '0;
      relStep  = doneSum[STEP_W-1:0];
    end else begin
      doneNext = DONE_W'(doneSum - (STEP_W+1)'(strobe.freeCnt));
      relStep  = strobe.freeCnt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prodIdx    <= '0;
      fetchIdx   <= '0;
      reclaimIdx <= '0;
      pendCnt    <= '0;
      doneCnt    <= '0;
      freeErr    <= 1'b0;
    end else begin
      pendCnt <= pendNext;
      doneCnt <= doneNext;
      if (strobe.addEn)     prodIdx    <= wrapAdd(prodIdx, strobe.addCnt, queueSize);
      if (strobe.fetchStep) fetchIdx   <= wrapAdd(fetchIdx, STEP_W'(1), queueSize);
      if (strobe.freeEn)    reclaimIdx <= wrapAdd(reclaimIdx, relStep, queueSize);
      if (overFree)         freeErr    <= 1'b1;
    end
  end

endmodule

// File: rtl/desc_ring_tracker.sv
module desc_ring_tracker
  import desc_ring_pkg::*;
#(
  parameter int IDX_W     = 13,
  parameter int DONE_W    = 15,
  parameter int DEPTH_MAX = 1 << IDX_W >> 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [2:0]       regAddr,
  input  logic [31:0]      regWrData,
  output logic [31:0]      regRdData,
  output logic             fetchReq,
  output logic [IDX_W-1:0] fetchIdx,
  input  logic             fetchGnt,
  input  logic             doneIn
);

  localparam int SIZE_W = IDX_W + 1;

  ringStrobe_t       strobe;
  logic [SIZE_W-1:0] queueSize;
  logic              hasWork;
  logic [IDX_W-1:0]  prodIdx;
  logic [IDX_W-1:0]  reclaimIdx;
  logic [DONE_W-1:0] doneCnt;
  logic              freeErr;

  ring_ctrl #(.IDX_W(IDX_W), .DONE_W(DONE_W), .DEPTH_MAX(DEPTH_MAX)) uCtrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .fetchGnt(fetchGnt), .doneIn(doneIn),
    .hasWork(hasWork), .prodIdx(prodIdx), .reclaimIdx(reclaimIdx),
    .doneCnt(doneCnt), .freeErr(freeErr),
    .fetchReq(fetchReq), .queueSize(queueSize), .strobe(strobe)
  );

  ring_datapath #(.IDX_W(IDX_W), .DONE_W(DONE_W)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .queueSize(queueSize),
    .prodIdx(prodIdx), .fetchIdx(fetchIdx), .reclaimIdx(reclaimIdx),
    .doneCnt(doneCnt), .freeErr(freeErr), .hasWork(hasWork)
  );

endmodule

// File: rtl/ring_checker.sv
module ring_checker #(
  parameter int IDX_W  = 13,
  parameter int DONE_W = 15,
  localparam int SIZE_W = IDX_W + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [2:0]        regAddr,
  input logic [31:0]       regWrData,
  input logic              fetchReq,
  input logic              fetchGnt,
  input logic [IDX_W-1:0]  fetchIdx,
  input logic              doneIn,
  input logic [DONE_W-1:0] doneCnt,
  input logic              freeErr,
  input logic [SIZE_W-1:0] queueSize
);

  logic [IDX_W-1:0] fetchNextExp;
  logic             freeWr;
  logic             overWr;

  assign fetchNextExp = ((SIZE_W'(fetchIdx) + SIZE_W'(1)) >= queueSize) ? '0 : fetchIdx + 1'b1;
  assign freeWr = regWrEn && (regAddr == 3'd2);
  assign overWr = freeWr && (regWrData > (32'(doneCnt) + 32'(doneIn)));

  assert_halt_blocks_R5: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 3'd3 && regWrData[0]) |=> !fetchReq);

  assert_fetch_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq && fetchGnt) |=> (fetchIdx == $past(fetchNextExp)));

  assert_fetch_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(fetchReq && fetchGnt) |=> $stable(fetchIdx));

  assert_done_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!doneIn && !freeWr) |=> $stable(doneCnt));

  assert_done_incr_R6: assert property (@(posedge clk) disable iff (!rstN)
    (doneIn && !freeWr) |=> (doneCnt == $past(doneCnt) + 1'b1));

  assert_over_free_R8: assert property (@(posedge clk) disable iff (!rstN)
    overWr |=> (freeErr && doneCnt == '0));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    freeErr |=> freeErr);

endmodule

bind desc_ring_tracker ring_checker #(.IDX_W(IDX_W), .DONE_W(DONE_W)) uChecker (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
  .fetchReq(fetchReq), .fetchGnt(fetchGnt), .fetchIdx(fetchIdx), .doneIn(doneIn),
  .doneCnt(doneCnt), .freeErr(freeErr), .queueSize(queueSize)
);

// File: tb/tb_desc_ring_tracker.sv
`timescale 1ns/1ps
module tb_desc_ring_tracker;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        fetchReq;
  logic [12:0] fetchIdx;
  logic        fetchGnt = 1'b0;
  logic        doneIn = 1'b0;

  int checks = 0;
  int errors = 0;
  int mSize = 4096, mProd = 0, mFetch = 0, mPend = 0, mDone = 0, mReclaim = 0;
  int mErr = 0, mStop = 1;

  always #5 clk = ~clk;

  desc_ring_tracker dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .fetchReq(fetchReq),
    .fetchIdx(fetchIdx), .fetchGnt(fetchGnt), .doneIn(doneIn)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic readReg(input int addr, output int val);
    regAddr = 3'(addr);
    #1;
    val = int'(regRdData);
  endtask

  // one clock with the given inputs; the model advances alongside
  task automatic tick(input bit wrEn, input int addr, input int data, input bit gnt, input bit dn);
    int nSize, nProd, nFetch, nPend, nDone, nRecl, nErr, nStop, sum;
    bit granted;
    @(negedge clk);
    regWrEn = wrEn; regAddr = 3'(addr); regWrData = data; fetchGnt = gnt; doneIn = dn;
    granted = (mPend != 0) && (mStop == 0) && gnt;
    nSize = mSize; nProd = mProd; nFetch = mFetch; nPend = mPend;
    nDone = mDone; nRecl = mReclaim; nErr = mErr; nStop = mStop;
    if (granted) begin nFetch = (mFetch + 1) % mSize; nPend = nPend - 1; end
    sum = mDone + int'(dn);
    nDone = sum;
    if (wrEn) begin
      case (addr)
        0: if (data >= 1 && data <= 4096) nSize = data;
        1: begin nProd = (mProd + data) % mSize; nPend = nPend + data; end
        2: if (data > sum) begin
             nDone = 0; nRecl = (mReclaim + sum) % mSize; nErr = 1;
           end else begin
             nDone = sum - data; nRecl = (mReclaim + data) % mSize;
           end
        3: nStop = data & 1;
        default: ;
      endcase
    end
    @(posedge clk);
    #1;
    regWrEn = 1'b0; fetchGnt = 1'b0; doneIn = 1'b0; regWrData = '0;
    mSize = nSize; mProd = nProd; mFetch = nFetch; mPend = nPend;
    mDone = nDone; mReclaim = nRecl; mErr = nErr; mStop = nStop;
  endtask

  task automatic checkState(input string rq);
    int v;
    readReg(4, v);
    check({rq, " done count"}, v & 32'h7fff, mDone);
    check({rq, " release index"}, (v >> 16) & 32'h1fff, mReclaim);
    check({rq, " error bit"}, (v >> 31) & 1, mErr);
    readReg(5, v);
    check({rq, " producer index"}, (v >> 16) & 32'hffff, mProd);
    check({rq, " fetchReq"}, int'(fetchReq), int'(mPend != 0 && mStop == 0));
    check({rq, " fetchIdx"}, int'(fetchIdx), mFetch);
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    // R1: reset values
    readReg(0, v); check("R1 size", v, 4096);
    readReg(3, v); check("R1 halt", v, 1);
    checkState("R1");

    // R2: out-of-range sizes ignored, in-range accepted
    tick(1, 0, 0, 0, 0);    readReg(0, v); check("R2 size zero ignored", v, 4096);
    tick(1, 0, 5000, 0, 0); readReg(0, v); check("R2 size big ignored", v, 4096);
    tick(1, 0, 8, 0, 0);    readReg(0, v); check("R2 size set", v, 8);

    // R5: work added while halted gives no request
    tick(1, 1, 3, 1, 0);  checkState("R5 halted add");
    tick(1, 3, 0, 0, 0);  checkState("R4 enabled");
    repeat (3) tick(0, 0, 0, 1, 0);
    checkState("R4 drained");
    // R3: producer wraps (3 + 7) mod 8 = 2
    tick(1, 1, 7, 0, 0);  checkState("R3 wrap");
    repeat (7) tick(0, 0, 0, 1, 1);
    checkState("R4 fetch wrap R6");
    // R7: release two
    tick(1, 2, 2, 0, 0);  checkState("R7 release");
    // R9: pulse and release together
    tick(1, 2, 1, 0, 1);  checkState("R9 collide");
    // R5: halt with work pending
    tick(1, 1, 4, 0, 0);
    tick(1, 3, 1, 0, 0);  checkState("R5 halt pending");
    tick(0, 0, 0, 1, 0);  checkState("R5 grant ignored");
    // R8: over-release saturates and sets sticky error
    tick(1, 2, 9, 0, 1);  checkState("R8 over release");
    tick(1, 2, 0, 0, 0);  checkState("R8 sticky");
    tick(1, 3, 0, 0, 0);

    // mixed random traffic, collisions of doneIn and release writes
    for (int i = 0; i < 400; i++) begin
      int op, n;
      bit g, d;
      op = int'($urandom % 10);
      g = ($urandom % 3) != 0;
      d = (($urandom % 3) == 0) && (mDone < mSize - 1);
      if (op < 3) begin
        n = int'($urandom % (mSize - mPend + 1));
        tick(1, 1, n, g, d);
      end else if (op < 6) begin
        n = int'($urandom % (mDone + 2));
        if (n > mSize) n = mSize;
        tick(1, 2, n, g, d);
      end else if (op == 6) begin
        tick(1, 3, int'($urandom % 4 == 0), g, d);
      end else begin
        tick(0, 0, 0, g, d);
      end
      checkState("R9 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule